// File: doc/BRIEF.md
# Oscillator Miscount Stepper with PPS Gating

This block counts the cycles of a local reference oscillator from one rising strobe of a once-per-second timing pulse to the next. It compares each total against the expected count for one second and classifies that second as on-count, over-count or under-count. From the classification it adjusts a tuning word for the oscillator's control DAC. A single miscount, or a run of miscounts that alternate in sign, is treated as quantisation jitter on the timing pulse and does not change the tuning word. The word moves by one step only when two consecutive seconds miscount in the same direction.

A timing pulse that goes missing (the running count passes the nominal total plus a margin) puts the block into a holdoff. During holdoff the tuning word is frozen. Normal tracking resumes after two intervals that end within the margin. The strobe is expected to be already synchronised to the oscillator clock and one clock wide.

A state machine drives the control. Its states are: SYNC (waiting for the first strobe after reset or enable; the partial interval is discarded), TRACK (no miscount pending), PEND_FAST (one over-count pending), PEND_SLOW (one under-count pending), HOLD_BAD (holdoff, no good interval yet) and HOLD_ONE (holdoff, one good interval seen). Its transitions on a strobe are:
- SYNC goes to TRACK.
- TRACK goes to PEND_FAST on over-count, to PEND_SLOW on under-count, and stays on on-count.
- PEND_FAST on over-count steps the word down and goes to TRACK. On under-count it goes to PEND_SLOW. On on-count it goes to TRACK.
- PEND_SLOW mirrors PEND_FAST, stepping the word up.
- HOLD_BAD goes to HOLD_ONE if the interval was within the limit, and otherwise stays.
- HOLD_ONE goes to TRACK if the interval was within the limit, and otherwise goes to HOLD_BAD.

Without a strobe, any state other than SYNC goes to HOLD_BAD once the count is over the limit. Enable low forces SYNC.

Top module: `pps_miscount_stepper`

## Requirements
- R1: While reset is held, the tuning word is mid-scale (only the top bit set), the status code is 2'b11, the latched count is 0 and the holdoff flag is 0.
- R2: The latched count equals the number of oscillator clock edges from one strobe edge to the next. It updates at the edge that samples the strobe, and the running counter restarts at 1 on that edge.
- R3: At each strobe the status code becomes 2'b00 if the count equals nominal, 2'b01 if above, and 2'b10 if below. The first strobe after reset or after enable returns gives 2'b11, and that interval is not used for tuning. The code does not change between strobes.
- R4: A single miscount with no same-sign miscount immediately before it leaves the tuning word unchanged.
- R5: Miscounts that alternate in sign never change the tuning word, however long they continue.
- R6: A second consecutive over-count lowers the tuning word by one, and a second consecutive under-count raises it by one, at the edge that samples the second strobe.
- R7: The pending miscount is cleared by a step and by an on-count second, so a third same-sign miscount does not step, and a fourth does.
- R8: The tuning word saturates at 0 and at all-ones instead of wrapping.
- R9: When the running count passes nominal plus the margin without a strobe, the holdoff flag rises and any pending miscount is dropped. While the flag is set the tuning word holds. The flag clears after two consecutive intervals whose counts are within nominal plus the margin.
- R10: With enable low, the running count is cleared, the status code is 2'b11, the holdoff flag is 0 and the tuning word keeps its value. The next strobe after enable rises is treated as the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock being measured |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Measurement enable; low restarts synchronisation |
| pps_i | input | 1 | Synchronised one-clock strobe of the timing pulse |
| dac_o | output | DAC_W | Oscillator tuning word |
| code_o | output | 2 | Classification of the last interval |
| count_o | output | CNT_W | Cycle count of the last interval |
| hold_o | output | 1 | Holdoff flag after a missing timing pulse |

## Verification
On every cycle, assertions check the following:
- The running counter restarts at one after a strobe and otherwise advances without wrapping.
- The status code moves only on a strobe.
- The tuning word never moves by more than one.
- The tuning word never wraps at either end.
- The tuning word is frozen while the holdoff flag is set.

Only the bench scenarios can show the sequence-dependent behaviour, by comparing against a behavioural model on every clock:
- Single and alternating miscounts do not step the word.
- Same-sign pairs step it in the right direction.
- The pending miscount is cleared after a step.
- Holdoff is entered on a missing pulse and left after two good intervals.
- Enable low restarts synchronisation.

// File: rtl/pps_step_pkg.sv
package pps_step_pkg;

    typedef enum logic [1:0] {
        SC_ON      = 2'b00,
        SC_OVER    = 2'b01,
        SC_UNDER   = 2'b10,
        SC_DISCARD = 2'b11
    } sec_code_t;

    typedef enum logic [2:0] {
        S_SYNC,
        S_TRACK,
        S_PEND_FAST,
        S_PEND_SLOW,
        S_HOLD_BAD,
        S_HOLD_ONE
    } trk_state_t;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_DOWN,
        STEP_UP
    } step_dir_t;

endpackage

// File: rtl/pps_cycle_counter.sv
module pps_cycle_counter
    import pps_step_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int NOMINAL = 10_000_000,
    parameter int MARGIN  = 1000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             pps_i,
    output logic [CNT_W-1:0] count_o,
    output sec_code_t        cls_o,
    output logic             over_lim_o
);

    localparam logic [CNT_W-1:0] NOM_C   = CNT_W'(NOMINAL);
    localparam logic [CNT_W-1:0] LIM_C   = CNT_W'(NOMINAL + MARGIN);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            count_q <= '0;
        end else if (!en_i) begin
            cnt_q   <= '0;
        end else if (pps_i) begin
            count_q <= cnt_q;
            cnt_q   <= CNT_W'(1);
        end else if (cnt_q != CNT_MAX) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (cnt_q == NOM_C)     cls_o = SC_ON;
        else if (cnt_q > NOM_C) cls_o = SC_OVER;
        else                    cls_o = SC_UNDER;
    end

    assign over_lim_o = (cnt_q > LIM_C);
    assign count_o    = count_q;

    // R2: counter restarts at one after each strobe
    a_r2_restart_at_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && pps_i) |=> (cnt_q == CNT_W'(1)));

    // R2: counter advances by one between strobes, without wrapping
    a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !pps_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/miscount_tracker.sv
module miscount_tracker
    import pps_step_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      pps_i,
    input  sec_code_t cls_i,
    input  logic      over_lim_i,
    output step_dir_t step_o,
    output sec_code_t code_o,
    output logic      hold_o
);

    trk_state_t state_q, state_d;
    sec_code_t  code_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_SYNC;
        else       state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = S_SYNC;
        end else if (pps_i) begin
            unique case (state_q)
                S_SYNC:      state_d = S_TRACK;
                S_TRACK:     state_d = (cls_i == SC_OVER)  ? S_PEND_FAST :
                                       (cls_i == SC_UNDER) ? S_PEND_SLOW : S_TRACK;
                S_PEND_FAST: state_d = (cls_i == SC_UNDER) ? S_PEND_SLOW : S_TRACK;
                S_PEND_SLOW: state_d = (cls_i == SC_OVER)  ? S_PEND_FAST : S_TRACK;
                S_HOLD_BAD:  state_d = over_lim_i ? S_HOLD_BAD : S_HOLD_ONE;
                S_HOLD_ONE:  state_d = over_lim_i ? S_HOLD_BAD : S_TRACK;
                default:     state_d = S_SYNC;
            endcase
        end else if (over_lim_i && state_q != S_SYNC) begin
            state_d = S_HOLD_BAD;
        end
    end

    // outputs
    always_comb begin
        step_o = STEP_NONE;
        if (en_i && pps_i) begin
            unique case (state_q)
                S_PEND_FAST: if (cls_i == SC_OVER)  step_o = STEP_DOWN;
                S_PEND_SLOW: if (cls_i == SC_UNDER) step_o = STEP_UP;
                default:     step_o = STEP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i)   code_q <= SC_DISCARD;
        else if (pps_i)       code_q <= (state_q == S_SYNC) ? SC_DISCARD : cls_i;
    end

    assign code_o = code_q;
    assign hold_o = (state_q == S_HOLD_BAD) || (state_q == S_HOLD_ONE);

    // R3: status code changes only on a strobe
    a_r3_code_on_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !pps_i) |=> $stable(code_o));

    // R9: no step requested during holdoff
    a_r9_no_step_in_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_o |-> (step_o == STEP_NONE));

endmodule

// File: rtl/dac_stepper.sv
module dac_stepper
    import pps_step_pkg::*;
#(
    parameter int DAC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  step_dir_t        step_i,
    output logic [DAC_W-1:0] dac_o
);

    localparam logic [DAC_W-1:0] DAC_MID = {1'b1, {(DAC_W-1){1'b0}}};
    localparam logic [DAC_W-1:0] DAC_MAX = '1;

    logic [DAC_W-1:0] dac_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dac_q <= DAC_MID;
        end else begin
            unique case (step_i)
                STEP_DOWN: if (dac_q != '0)     dac_q <= dac_q - 1'b1;
                STEP_UP:   if (dac_q != DAC_MAX) dac_q <= dac_q + 1'b1;
                default:   dac_q <= dac_q;
            endcase
        end
    end

    assign dac_o = dac_q;

    // R6: the word moves by at most one per edge
    a_r6_unit_step: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (dac_q == $past(dac_q) || dac_q == $past(dac_q) + 1'b1
                  || dac_q == $past(dac_q) - 1'b1));

    // R8: saturation at both ends
    a_r8_no_wrap_top: assert property (@(posedge clk_i) disable iff (rst_i)
        (dac_q == DAC_MAX && step_i == STEP_UP) |=> (dac_q == DAC_MAX));
    a_r8_no_wrap_bottom: assert property (@(posedge clk_i) disable iff (rst_i)
        (dac_q == '0 && step_i == STEP_DOWN) |=> (dac_q == '0));

endmodule

// File: rtl/pps_miscount_stepper.sv
module pps_miscount_stepper
    import pps_step_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int DAC_W   = 16,
    parameter int NOMINAL = 10_000_000,
    parameter int MARGIN  = 1000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             pps_i,
    output logic [DAC_W-1:0] dac_o,
    output logic [1:0]       code_o,
    output logic [CNT_W-1:0] count_o,
    output logic             hold_o
);

    sec_code_t cls;
    sec_code_t code;
    step_dir_t step;
    logic      over_lim;

    pps_cycle_counter #(
        .CNT_W(CNT_W), .NOMINAL(NOMINAL), .MARGIN(MARGIN)
    ) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .pps_i(pps_i),
        .count_o(count_o), .cls_o(cls), .over_lim_o(over_lim)
    );

    miscount_tracker u_trk (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .pps_i(pps_i),
        .cls_i(cls), .over_lim_i(over_lim),
        .step_o(step), .code_o(code), .hold_o(hold_o)
    );

    dac_stepper #(.DAC_W(DAC_W)) u_dac (
        .clk_i(clk_i), .rst_i(rst_i), .step_i(step), .dac_o(dac_o)
    );

    assign code_o = code;

    // R9: the tuning word is frozen while holdoff is set
    a_r9_hold_freezes: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_o |=> $stable(dac_o));

endmodule

// File: tb/sim_pps_miscount_stepper.sv
module sim_pps_miscount_stepper;

    localparam int CLK_PER = 10;
    localparam int NOM  = 20;
    localparam int MARG = 5;
    localparam int LIM  = NOM + MARG;
    localparam int CW   = 16;
    localparam int DW   = 4;
    localparam int MID  = 1 << (DW - 1);
    localparam int DMAX = (1 << DW) - 1;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 0;
    logic rst = 1;
    logic en  = 1;
    logic pps = 0;
    logic [DW-1:0] dac_o;
    logic [1:0]    code_o;
    logic [CW-1:0] count_o;
    logic          hold_o;

    int total = 0;
    int bad   = 0;
    bit chk_on = 0;
    bit done   = 0;

    // reference model state
    int m_cnt, m_count, m_code, m_dac, m_hold, m_phase, m_pend, m_good;

    always #(CLK_PER/2) clk = ~clk;

    pps_miscount_stepper #(
        .CNT_W(CW), .DAC_W(DW), .NOMINAL(NOM), .MARGIN(MARG)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .pps_i(pps),
        .dac_o(dac_o), .code_o(code_o), .count_o(count_o), .hold_o(hold_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, phase 0 = waiting, 1 = tracking, 2 = holdoff
    always @(posedge clk) begin
        int c;
        if (rst) begin
            m_cnt = 0; m_count = 0; m_code = 3; m_dac = MID;
            m_hold = 0; m_phase = 0; m_pend = 0; m_good = 0;
        end else if (!en) begin
            m_cnt = 0; m_code = 3; m_hold = 0; m_phase = 0; m_pend = 0;
        end else if (pps) begin
            c = (m_cnt == NOM) ? 0 : (m_cnt > NOM) ? 1 : 2;
            m_count = m_cnt;
            if (m_phase == 0) begin
                m_code = 3; m_phase = 1; m_pend = 0;
            end else begin
                m_code = c;
                if (m_phase == 1) begin
                    if (c == 0) m_pend = 0;
                    else if (m_pend == c) begin
                        if (c == 1 && m_dac > 0) m_dac--;
                        if (c == 2 && m_dac < DMAX) m_dac++;
                        m_pend = 0;
                    end else m_pend = c;
                end else begin
                    if (m_cnt > LIM) m_good = 0; else m_good++;
                    if (m_good == 2) begin m_phase = 1; m_hold = 0; m_pend = 0; end
                end
            end
            m_cnt = 1;
        end else begin
            if (m_phase != 0 && m_cnt > LIM) begin
                m_phase = 2; m_hold = 1; m_good = 0; m_pend = 0;
            end
            if (m_cnt < CMAX) m_cnt++;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            check("R2 count", int'(count_o), m_count);
            check("R3 code", int'(code_o), m_code);
            check("R6 dac", int'(dac_o), m_dac);
            check("R9 hold", int'(hold_o), m_hold);
        end
    end

    // strobe n clocks after the previous one (n >= 2)
    task automatic pulse(input int n);
        repeat (n - 2) @(negedge clk) pps = 0;
        @(negedge clk) pps = 1;
        @(negedge clk) pps = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 dac", int'(dac_o), MID);
        check("R1 code", int'(code_o), 3);
        check("R1 count", int'(count_o), 0);
        check("R1 hold", int'(hold_o), 0);
        rst = 0;
        chk_on = 1;

        pulse(7);
        check("R3 first discarded", int'(code_o), 3);
        pulse(20);
        check("R2 count", int'(count_o), 20);
        check("R3 on", int'(code_o), 0);
        pulse(21);
        check("R3 over", int'(code_o), 1);
        check("R4 single over", int'(dac_o), 8);
        pulse(20);
        pulse(19);
        check("R3 under", int'(code_o), 2);
        check("R4 single under", int'(dac_o), 8);

        for (int i = 0; i < 6; i++) begin pulse(21); pulse(19); end
        check("R5 alternating", int'(dac_o), 8);

        pulse(21); pulse(21);
        check("R6 step down", int'(dac_o), 7);
        pulse(21);
        check("R7 third no step", int'(dac_o), 7);
        pulse(21);
        check("R7 fourth steps", int'(dac_o), 6);
        pulse(19); pulse(19);
        check("R6 step up", int'(dac_o), 7);

        for (int i = 0; i < 10; i++) begin pulse(22); pulse(22); end
        check("R8 floor", int'(dac_o), 0);
        for (int i = 0; i < 17; i++) begin pulse(18); pulse(18); end
        check("R8 ceiling", int'(dac_o), DMAX);

        pulse(60);
        check("R9 hold set", int'(hold_o), 1);
        pulse(21);
        check("R9 still hold", int'(hold_o), 1);
        pulse(21);
        check("R9 hold cleared", int'(hold_o), 0);
        check("R9 frozen", int'(dac_o), DMAX);
        pulse(21);
        check("R9 pending dropped", int'(dac_o), DMAX);
        pulse(21);
        check("R6 after hold", int'(dac_o), DMAX - 1);

        @(negedge clk) en = 0;
        repeat (3) @(negedge clk);
        check("R10 code", int'(code_o), 3);
        check("R10 dac kept", int'(dac_o), DMAX - 1);
        check("R10 hold", int'(hold_o), 0);
        en = 1;
        pulse(5);
        check("R10 first discarded", int'(code_o), 3);
        pulse(20);
        check("R10 resumed", int'(code_o), 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule